// File: doc/BRIEF.md
# CAN Bus Fault Qualifier

This block sits behind the analog fault comparators of a two-wire CAN transceiver. It turns their raw output into a qualified diagnosis. Three asynchronous inputs are brought onto the system clock through two-flop synchronisers: the transmit-driven bus level (recessive or dominant), a fault-present flag and a two-bit fault class. The block then counts complete bus cycles, each one a recessive interval followed by a dominant interval. A fault is first reported as suspected. It counts as identified only when the same class has been seen during the dominant part of five consecutive cycles. Only then is the fault routed to the diagnostic field of the affected wire.

A three-bit summary word carries a sticky failure flag, which sets on any fault, even with the bus idle. It also carries a live "unidentified" flag. Each wire has its own sticky diagnostic field: one for the low wire and one for the high wire. A read-clear strobe empties the sticky bits, but only once the fault has gone away.

Top module: `canbus_fault_qual`

## Requirements
- R1: `bus_dom_i`, `fault_i` and `fault_code_i` pass through two synchroniser flops before use. A fault raised with all else quiet shows on `status_o[2]` after the third rising clock edge. After reset the synchronised bus level reads dominant.
- R2: `status_o[2]` (failure) sets whenever the synchronised fault flag is 1. This holds with the bus idle and no transitions.
- R3: `status_o[1]` (unidentified) is 1 when the synchronised fault flag is 1 and the fault is not yet identified. Otherwise it is 0. `status_o[0]` always reads 0.
- R4: A bus cycle completes when the synchronised bus returns to recessive after a dominant interval that itself followed a recessive sample seen since reset. A dominant interval present at reset release is not counted.
- R5: A fault becomes identified once five consecutive completed cycles each carried the fault flag during their dominant interval with the same class. The class of a cycle is the last class sampled with the fault flag set while dominant. When a fault is identified, `status_o[1]` goes to 0.
- R6: A completed cycle whose class differs from the one being qualified restarts the count at one. A completed cycle with no fault during its dominant interval resets the count to zero and clears identification.
- R7: Fault class bit 1 selects the wire (0 low, 1 high). Bit 0 selects the rail (0 ground, 1 supply). While a fault is present and identified, bit [rail] of `low_diag_o` or `high_diag_o` is set.
- R8: `status_o[2]` and both diagnostic fields hold until `clear_i` is sampled high while the synchronised fault flag is 0. A clear sampled while the fault is present has no effect.
- R9: A fault seen only during recessive intervals never advances the count, so it stays unidentified and reaches no diagnostic field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_dom_i | input | 1 | Transmit-driven bus level, 1 = dominant (asynchronous) |
| fault_i | input | 1 | Raw fault-present flag from the comparators (asynchronous) |
| fault_code_i | input | 2 | Raw fault class: bit 1 wire, bit 0 rail |
| clear_i | input | 1 | Read-clear strobe for the sticky bits |
| status_o | output | 3 | Summary: bit 2 failure, bit 1 unidentified, bit 0 zero |
| low_diag_o | output | 2 | Low-wire field: bit 0 short to ground, bit 1 short to supply |
| high_diag_o | output | 2 | High-wire field: bit 0 short to ground, bit 1 short to supply |

## Verification
The bench targets the following corner cases:

- **Reset with a dominant bus.** A design that counts the first dominant interval would identify the fault one cycle early.
- **Class change midway.** A design that kept counting would identify after too few cycles with the new class.
- **Fault-free gap between faulted cycles.** A design without a zero reset would fill the diagnostic field early.
- **Fault present only while recessive.** A design that qualifies on any sample would write a diagnostic field it must leave empty.
- **Read-clear while the fault persists.** A design that clears unconditionally would drop the failure flag and fields.

It also times the idle-bus failure flag against the two-flop synchroniser latency.

// File: rtl/canq_pkg.sv
package canq_pkg;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned DIAG_W   = 2;
  localparam int unsigned N_WIRES  = 2;
  localparam int unsigned WIRE_BIT = 1;
  localparam int unsigned RAIL_BIT = 0;

  typedef logic [CODE_W-1:0] fcode_t;
  typedef logic [DIAG_W-1:0] diag_t;

  typedef struct packed {
    logic fail;
    logic unid;
    logic rsvd;
  } summ_t;
endpackage

// File: rtl/canq_sync.sv
module canq_sync #(
  parameter int unsigned         WIDTH   = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/canq_cycle_trk.sv
module canq_cycle_trk
  import canq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   dom_i,
  input  logic   fault_i,
  input  fcode_t code_i,
  output logic   done_o,
  output logic   cyc_fault_o,
  output fcode_t cyc_code_o
);
  logic   rec_seen_q, in_dom_q, dfault_q;
  fcode_t dcode_q;
  logic   dom_valid;

  // dominant sample that belongs to a cycle opened by a recessive interval
  assign dom_valid = dom_i & rec_seen_q;
  assign done_o    = ~dom_i & in_dom_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_seen_q <= 1'b0;
      in_dom_q   <= 1'b0;
      dfault_q   <= 1'b0;
      dcode_q    <= '0;
    end else begin
      if (!dom_i) rec_seen_q <= 1'b1;
      in_dom_q <= dom_valid;
      if (dom_valid) begin
        dfault_q <= in_dom_q ? (dfault_q | fault_i) : fault_i;
        if (fault_i) dcode_q <= code_i;
      end
    end
  end

  assign cyc_fault_o = dfault_q;
  assign cyc_code_o  = dcode_q;
endmodule

// File: rtl/canq_qual.sv
module canq_qual
  import canq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 5,
  localparam int unsigned CNT_W      = $clog2(QUAL_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             cyc_fault_i,
  input  fcode_t           cyc_code_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ident_o,
  output fcode_t           code_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  fcode_t           code_q, code_d;
  logic             same;

  assign same = (cnt_q != '0) && (cyc_code_i == code_q);

  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    if (done_i) begin
      if (!cyc_fault_i) begin
        cnt_d = '0;
      end else if (same) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d  = CNT_W'(1);
        code_d = cyc_code_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign ident_o = (cnt_q == CNT_MAX);
  assign code_o  = code_q;
endmodule

// File: rtl/canq_report.sv
module canq_report
  import canq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fault_i,
  input  logic   ident_i,
  input  fcode_t code_i,
  input  logic   clear_i,
  output summ_t  summ_o,
  output diag_t  low_o,
  output diag_t  high_o
);
  logic  fail_q, unid_q;
  logic  clr_ok;
  diag_t diag_q [N_WIRES];

  // clear is honoured only once the fault has gone
  assign clr_ok = clear_i & ~fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      unid_q <= 1'b0;
    end else begin
      fail_q <= fault_i | (fail_q & ~clr_ok);
      unid_q <= fault_i & ~ident_i;
    end
  end

  for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
    diag_t set_vec;
    always_comb begin
      set_vec = '0;
      if (fault_i && ident_i && (code_i[WIRE_BIT] == w[0]))
        set_vec[code_i[RAIL_BIT]] = 1'b1;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) diag_q[w] <= '0;
      else         diag_q[w] <= set_vec | (diag_q[w] & {DIAG_W{~clr_ok}});
    end
  end

  assign summ_o = '{fail: fail_q, unid: unid_q, rsvd: 1'b0};
  assign low_o  = diag_q[0];
  assign high_o = diag_q[1];
endmodule

// File: rtl/canbus_fault_qual.sv
module canbus_fault_qual
  import canq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(QUAL_CYCLES + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_dom_i,
  input  logic        fault_i,
  input  logic [1:0]  fault_code_i,
  input  logic        clear_i,
  output logic [2:0]  status_o,
  output logic [1:0]  low_diag_o,
  output logic [1:0]  high_diag_o
);
  logic             dom_s, fault_s;
  fcode_t           code_s;
  logic             cyc_done, cyc_fault;
  fcode_t           cyc_code, qual_code;
  logic [CNT_W-1:0] qual_cnt;
  logic             ident;
  summ_t            summ;
  diag_t            low_d, high_d;

  // bus resets to dominant so a dominant level at reset release is not a cycle
  canq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bus (
    .clk_i, .rst_ni, .d_i(bus_dom_i), .q_o(dom_s)
  );

  canq_sync #(.WIDTH(CODE_W + 1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_flt (
    .clk_i, .rst_ni, .d_i({fault_i, fault_code_i}), .q_o({fault_s, code_s})
  );

  canq_cycle_trk u_cyc (
    .clk_i, .rst_ni,
    .dom_i(dom_s), .fault_i(fault_s), .code_i(code_s),
    .done_o(cyc_done), .cyc_fault_o(cyc_fault), .cyc_code_o(cyc_code)
  );

  canq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk_i, .rst_ni,
    .done_i(cyc_done), .cyc_fault_i(cyc_fault), .cyc_code_i(cyc_code),
    .cnt_o(qual_cnt), .ident_o(ident), .code_o(qual_code)
  );

  canq_report u_rep (
    .clk_i, .rst_ni,
    .fault_i(fault_s), .ident_i(ident), .code_i(qual_code), .clear_i,
    .summ_o(summ), .low_o(low_d), .high_o(high_d)
  );

  assign status_o    = summ;
  assign low_diag_o  = low_d;
  assign high_diag_o = high_d;
endmodule

// File: rtl/canbus_fault_qual_chk.sv
module canbus_fault_qual_chk #(
  parameter int unsigned QUAL_CYCLES = 5,
  localparam int unsigned CNT_W      = $clog2(QUAL_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic [2:0]       status_i,
  input logic [1:0]       low_i,
  input logic [1:0]       high_i,
  input logic             done_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ident_i
);
  // R3
  unid_needs_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[1] |-> status_i[2]);

  // R8
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_i[2]) && !$past(clear_i)) |-> status_i[2]);

  // R8
  diag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> (((low_i & $past(low_i)) == $past(low_i)) &&
                         ((high_i & $past(high_i)) == $past(high_i))));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(QUAL_CYCLES));

  // R6
  cnt_only_on_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(cnt_i));

  // R7
  diag_rise_needs_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(low_i & ~$past(low_i))) || (|(high_i & ~$past(high_i)))) |-> $past(ident_i));
endmodule

bind canbus_fault_qual canbus_fault_qual_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .status_i(status_o),
  .low_i   (low_diag_o),
  .high_i  (high_diag_o),
  .done_i  (cyc_done),
  .cnt_i   (qual_cnt),
  .ident_i (ident)
);

// File: tb/canbus_fault_qual_bench.sv
module canbus_fault_qual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_dom = 1'b0;
  logic       fault = 1'b0;
  logic [1:0] code = 2'd0;
  logic       clr = 1'b0;
  logic [2:0] status;
  logic [1:0] low_diag, high_diag;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  canbus_fault_qual u_canbus_fault_qual (
    .clk_i(clk), .rst_ni(rst_n), .bus_dom_i(bus_dom), .fault_i(fault),
    .fault_code_i(code), .clear_i(clr), .status_o(status),
    .low_diag_o(low_diag), .high_diag_o(high_diag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: two-edge delay queues and integer counters
  int q_dom[$], q_flt[$], q_code[$];
  bit m_rec_seen, m_in_dom, m_dfault, m_fail, m_unid;
  int m_dcode, m_cnt, m_code;
  int m_diag[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_dom = '{1, 1}; q_flt = '{0, 0}; q_code = '{0, 0};
      m_rec_seen = 0; m_in_dom = 0; m_dfault = 0; m_fail = 0; m_unid = 0;
      m_dcode = 0; m_cnt = 0; m_code = 0; m_diag = '{0, 0};
    end else begin
      int d, f, c;
      bit ident, fin, dv, clr_ok;
      d = q_dom[0]; f = q_flt[0]; c = q_code[0];
      ident  = (m_cnt == 5);
      fin    = (d == 0) && m_in_dom;
      dv     = (d == 1) && m_rec_seen;
      clr_ok = clr && (f == 0);
      for (int w = 0; w < 2; w++) if (clr_ok) m_diag[w] = 0;
      if (ident && f == 1) m_diag[m_code / 2] |= (1 << (m_code % 2));
      m_fail = (f == 1) || (m_fail && !clr_ok);
      m_unid = (f == 1) && !ident;
      if (fin) begin
        if (!m_dfault) m_cnt = 0;
        else if (m_cnt != 0 && m_dcode == m_code) m_cnt = (m_cnt < 5) ? m_cnt + 1 : 5;
        else begin m_cnt = 1; m_code = m_dcode; end
      end
      if (dv) begin
        m_dfault = m_in_dom ? (m_dfault || f == 1) : (f == 1);
        if (f == 1) m_dcode = c;
      end
      m_in_dom = dv;
      if (d == 0) m_rec_seen = 1;
      q_dom.push_back(int'(bus_dom)); void'(q_dom.pop_front());
      q_flt.push_back(int'(fault));   void'(q_flt.pop_front());
      q_code.push_back(int'(code));   void'(q_code.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 fail bit", int'(status[2]), int'(m_fail));
      chk("R3 unid bit", int'(status[1]), int'(m_unid));
      chk("R3 bit0", int'(status[0]), 0);
      chk("R7 low field", int'(low_diag), m_diag[0]);
      chk("R7 high field", int'(high_diag), m_diag[1]);
    end
  end

  task automatic bus_cycle(input bit f_rec, input bit f_dom, input int c);
    @(negedge clk); bus_dom = 1'b0; fault = f_rec; code = 2'(c);
    repeat (3) @(negedge clk);
    bus_dom = 1'b1; fault = f_dom;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle(input bit f);
    bus_dom = 1'b0; fault = f;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  task automatic do_reset(input bit dom);
    rst_n = 1'b0; bus_dom = dom; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    fault = 1'b0;
    @(negedge clk);
    chk("R3 reset status", int'(status), 0);
    chk("R8 reset fields", int'({low_diag, high_diag}), 0);

    // idle bus fault, synchroniser latency
    fault = 1'b1; code = 2'd0;
    repeat (2) @(negedge clk);
    chk("R1 fail not before third edge", int'(status[2]), 0);
    @(negedge clk);
    chk("R1 R2 idle fault flag", int'(status), 3'b110);

    // four cycles low/ground: still unidentified
    repeat (4) bus_cycle(1, 1, 0);
    settle(1);
    chk("R5 four cycles unid", int'(status), 3'b110);
    chk("R5 four cycles no field", int'(low_diag), 0);
    bus_cycle(1, 1, 0);
    settle(1);
    chk("R5 identified status", int'(status), 3'b100);
    chk("R7 low ground field", int'(low_diag), 2'b01);

    pulse_clear();
    chk("R8 clear ignored fail", int'(status[2]), 1);
    chk("R8 clear ignored field", int'(low_diag), 2'b01);

    settle(0);
    chk("R8 sticky after fault gone", int'({status[2], low_diag}), 3'b101);
    pulse_clear();
    chk("R8 cleared", int'({status, low_diag}), 0);
    bus_cycle(0, 0, 0); settle(0);

    // class change restarts qualification
    repeat (3) bus_cycle(1, 1, 3);
    repeat (4) bus_cycle(1, 1, 2);
    settle(1);
    chk("R6 restart unid", int'(status[1]), 1);
    chk("R6 restart no field", int'(high_diag), 0);
    bus_cycle(1, 1, 2);
    settle(1);
    chk("R7 high ground field", int'(high_diag), 2'b01);
    chk("R6 identified after restart", int'(status[1]), 0);
    settle(0); pulse_clear();
    bus_cycle(0, 0, 0); settle(0);

    // fault only while recessive
    repeat (6) bus_cycle(1, 0, 1);
    settle(1);
    chk("R9 recessive-only unid", int'(status[1]), 1);
    chk("R9 recessive-only no field", int'({low_diag, high_diag}), 0);
    settle(0); pulse_clear();

    // fault-free cycle resets the count
    repeat (3) bus_cycle(1, 1, 0);
    bus_cycle(1, 0, 0);
    repeat (4) bus_cycle(1, 1, 0);
    settle(1);
    chk("R6 gap resets count", int'(low_diag), 0);
    bus_cycle(1, 1, 0);
    settle(1);
    chk("R6 identified after gap", int'(low_diag), 2'b01);

    // dominant at reset release is not a cycle
    fault = 1'b1; code = 2'd1;
    do_reset(1'b1);
    repeat (4) @(negedge clk);
    repeat (4) bus_cycle(1, 1, 1);
    settle(1);
    chk("R4 initial dominant not counted", int'(low_diag), 0);
    chk("R4 still unid", int'(status[1]), 1);
    bus_cycle(1, 1, 1);
    settle(1);
    chk("R4 R7 low supply field", int'(low_diag), 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule